// File: doc/BRIEF.md
# Chip Erase Retry Controller

This controller runs the complete erase sequence for an external electrically erasable byte-wide memory array. On a start request it first writes 00h into every location, so that all cells sit at the same charge level before erasure. It then enters a loop. Each pass applies one chip-erase pulse with both high-voltage enables raised. A quiet recovery interval follows, and then a read-back of the array that checks every bit is one.

The read-back stops at the first location that does not return all ones, and the next erase pulse follows at once. The loop ends with a pass when a full sweep reads back clean. It ends with a fail when the verify after the last permitted pulse still finds a bad byte. The controller reports busy, a one-cycle done strobe and a pass flag. It also reports the number of erase pulses it applied, and this count stays on its output until the next start.

The pulse widths and the recovery time are parameters in clock cycles, so one design serves any clock rate. The controller only drives logic-level enables for the two high-voltage switches. Supply generation and regulation sit outside the block.

Top module: `erase_retry_ctl`

## Requirements
- R1: After reset and while idle: ce_n=1, oe_n=1, a9_hv=0, vpp_hv=0, busy=0, done=0, attempts=0.
- R2: After start, and before any erase pulse, every address from 0 up to 2^ADDR_W-1 is programmed in ascending order. Each location gets mem_wdata=00h, with vpp_hv=1, a9_hv=0, and ce_n low for exactly PROG_CYC cycles. The address and the vpp_hv level are already present one cycle before ce_n falls.
- R3: Each erase pulse holds a9_hv=1, vpp_hv=1 and ce_n=0 for exactly ERS_CYC cycles. Both enables are high for one cycle before ce_n falls.
- R4: After each erase pulse, ce_n=1, oe_n=1, a9_hv=0 and vpp_hv=0 hold for at least REC_CYC cycles before the first verify read.
- R5: A verify read holds ce_n=0 and oe_n=0 with both high-voltage enables low, for two cycles per address. mem_rdata is sampled on the second of these cycles. Addresses are read in ascending order, and a location passes only when all DATA_W bits read one.
- R6: The first failing location ends the verify sweep. No further address is read, and the next erase pulse begins.
- R7: attempts rises by one at each erase pulse. If verify fails after pulse number MAX_TRIES, the run ends with pass=0 and attempts=MAX_TRIES. A clean verify after pulse MAX_TRIES still ends with pass=1.
- R8: done is high for exactly one cycle, in the first cycle with busy=0. pass and attempts keep their final values until the next start, and start clears attempts to 0.
- R9: A start pulse while busy=1 has no effect on the sequence or on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a run while idle |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle strobe at the end of a run |
| pass | output | 1 | Run result, valid from done until next start |
| attempts | output | $clog2(MAX_TRIES+1) | Erase pulses applied in the current or last run |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_wdata | output | DATA_W | Program data (always zero) |
| mem_rdata | input | DATA_W | Data read back from the memory |
| ce_n | output | 1 | Chip enable, active low; program and erase pulse strobe |
| oe_n | output | 1 | Output enable, active low at logic level |
| a9_hv | output | 1 | Enable for the high-voltage level on the address-9 line |
| vpp_hv | output | 1 | Enable for the high-voltage level on the output-enable/program-supply line |

## Verification
Two decisions can land in the same verify cycle. One is the mismatch at the highest address, which would otherwise have completed a clean sweep. The other is the attempt limit, which decides between a retry and a final fail. The bench provokes this with a memory model whose top location never erases. It expects a fail at MAX_TRIES attempts, with 160 read cycles for 16 locations and five pulses. A second run lets the array erase on exactly the last permitted pulse, and this success must be reported as a pass rather than a fail. Other runs abort the verify on the first bad address, and one run pokes start mid-run. In each case the bench compares the total number of read cycles and the final count against values worked out from the requirements.

// File: rtl/ers_ctl_pkg.sv
package ers_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRG_SET,
    ST_PRG_PULSE,
    ST_ERS_SET,
    ST_ERS_PULSE,
    ST_RECOV,
    ST_VRF_SET,
    ST_VRF_CHK
  } ers_state_t;
endpackage

// File: rtl/ers_ctl_timer.sv
module ers_ctl_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val - TW'(1);
    else if (cnt != '0) cnt <= cnt - TW'(1);
  end

  assign expired = (cnt == '0);

  // R3
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));
endmodule

// File: rtl/ers_ctl_addr.sv
module ers_ctl_addr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (clr)  addr <= '0;
    else if (inc)  addr <= addr + ADDR_W'(1);
  end

  assign last = &addr;

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !last);
endmodule

// File: rtl/erase_retry_ctl.sv
module erase_retry_ctl
  import ers_ctl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PROG_CYC  = 6250,
  parameter int ERS_CYC   = 125000000,
  parameter int REC_CYC   = 500,
  parameter int MAX_TRIES = 200,
  localparam int CNT_W    = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [CNT_W-1:0]  attempts,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ce_n,
  output logic              oe_n,
  output logic              a9_hv,
  output logic              vpp_hv
);
  localparam int MAX_PR = (PROG_CYC > REC_CYC) ? PROG_CYC : REC_CYC;
  localparam int MAX_CY = (ERS_CYC > MAX_PR) ? ERS_CYC : MAX_PR;
  localparam int TW     = $clog2(MAX_CY + 1);

  ers_state_t    st, nxt;
  logic          t_load, t_exp;
  logic [TW-1:0] t_val;
  logic          a_clr, a_inc, a_last;
  logic          att_inc, fin, fin_pass;
  logic          done_q, pass_q;
  logic [CNT_W-1:0] att_q;

  ers_ctl_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  ers_ctl_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(a_clr), .inc(a_inc), .addr(mem_addr), .last(a_last)
  );

  always_comb begin
    nxt      = st;
    t_load   = 1'b0;
    t_val    = '0;
    a_clr    = 1'b0;
    a_inc    = 1'b0;
    att_inc  = 1'b0;
    fin      = 1'b0;
    fin_pass = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        nxt   = ST_PRG_SET;
        a_clr = 1'b1;
      end
      ST_PRG_SET: begin
        nxt    = ST_PRG_PULSE;
        t_load = 1'b1;
        t_val  = TW'(PROG_CYC);
      end
      ST_PRG_PULSE: if (t_exp) begin
        if (a_last) begin
          nxt   = ST_ERS_SET;
          a_clr = 1'b1;
        end else begin
          nxt   = ST_PRG_SET;
          a_inc = 1'b1;
        end
      end
      ST_ERS_SET: begin
        nxt     = ST_ERS_PULSE;
        t_load  = 1'b1;
        t_val   = TW'(ERS_CYC);
        att_inc = 1'b1;
      end
      ST_ERS_PULSE: if (t_exp) begin
        nxt    = ST_RECOV;
        t_load = 1'b1;
        t_val  = TW'(REC_CYC);
        a_clr  = 1'b1;
      end
      ST_RECOV:   if (t_exp) nxt = ST_VRF_SET;
      ST_VRF_SET: nxt = ST_VRF_CHK;
      ST_VRF_CHK: begin
        if (&mem_rdata) begin
          if (a_last) begin
            nxt      = ST_IDLE;
            fin      = 1'b1;
            fin_pass = 1'b1;
          end else begin
            nxt   = ST_VRF_SET;
            a_inc = 1'b1;
          end
        end else if (att_q == CNT_W'(MAX_TRIES)) begin
          nxt = ST_IDLE;
          fin = 1'b1;
        end else begin
          nxt = ST_ERS_SET;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      att_q  <= '0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      st     <= nxt;
      done_q <= fin;
      if (st == ST_IDLE && start) begin
        att_q  <= '0;
        pass_q <= 1'b0;
      end else begin
        if (att_inc) att_q  <= att_q + CNT_W'(1);
        if (fin)     pass_q <= fin_pass;
      end
    end
  end

  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign pass      = pass_q;
  assign attempts  = att_q;
  assign mem_wdata = '0;
  assign ce_n      = !(st inside {ST_PRG_PULSE, ST_ERS_PULSE, ST_VRF_SET, ST_VRF_CHK});
  assign oe_n      = !(st inside {ST_VRF_SET, ST_VRF_CHK});
  assign vpp_hv    = st inside {ST_PRG_SET, ST_PRG_PULSE, ST_ERS_SET, ST_ERS_PULSE};
  assign a9_hv     = st inside {ST_ERS_SET, ST_ERS_PULSE};

  // Checker counter for the erase pulse width
  logic [TW-1:0] ers_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ers_len <= '0;
    else if (a9_hv && !ce_n)  ers_len <= ers_len + TW'(1);
    else                      ers_len <= '0;
  end

  // R3
  ers_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!a9_hv || ce_n) && ers_len != '0) |-> (ers_len == TW'(ERS_CYC)));
  // R3
  hv_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a9_hv |-> vpp_hv);
  // R5
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && !vpp_hv && !a9_hv));
  // R7
  attempt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attempts <= CNT_W'(MAX_TRIES));
  // R8
  done_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(attempts));
endmodule

// File: tb/erase_retry_ctl_test.sv
module erase_retry_ctl_test;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int PC = 3;
  localparam int EC = 20;
  localparam int RC = 4;
  localparam int MT = 5;
  localparam int CW = $clog2(MT + 1);
  localparam int NLOC = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, pass, ce_n, oe_n, a9_hv, vpp_hv;
  logic [CW-1:0] attempts;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  erase_retry_ctl #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYC(PC), .ERS_CYC(EC),
                    .REC_CYC(RC), .MAX_TRIES(MT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .pass(pass),
    .attempts(attempts), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ce_n(ce_n), .oe_n(oe_n), .a9_hv(a9_hv), .vpp_hv(vpp_hv)
  );

  int total = 0;
  int passed = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  // Memory model
  logic [DW-1:0] mem [NLOC];
  logic reinit = 1'b0;
  int   need = 1;
  int   stuck = -1;
  int   ers_done;
  logic prev_ers, first_seen, pre_bad;

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    logic in_ers;
    if (reinit) begin
      for (int i = 0; i < NLOC; i++) mem[i] <= DW'(i * 37 + 5);
      ers_done   <= 0;
      prev_ers   <= 1'b0;
      first_seen <= 1'b0;
      pre_bad    <= 1'b0;
    end else begin
      in_ers = vpp_hv && a9_hv && !ce_n;
      if (vpp_hv && !a9_hv && !ce_n) mem[mem_addr] <= mem[mem_addr] & mem_wdata;
      if (in_ers && !prev_ers && !first_seen) begin
        first_seen <= 1'b1;
        for (int i = 0; i < NLOC; i++) if (mem[i] != '0) pre_bad <= 1'b1;
      end
      if (!in_ers && prev_ers) begin
        ers_done <= ers_done + 1;
        if (ers_done + 1 >= need)
          for (int i = 0; i < NLOC; i++) mem[i] <= (i == stuck) ? 8'h00 : 8'hFF;
      end
      prev_ers <= in_ers;
    end
  end

  // Scoreboard
  typedef struct { bit ok; int att; int reads; } exp_t;
  exp_t q[$];

  int  prog_n, prog_len, prog_err, ers_len, ers_err, gap, rec_err, reads, rd_err;
  bit  after_ers, p_ce_n, p_vpp, p_a9;
  logic [AW-1:0] p_addr;

  always @(negedge clk) begin
    if (!rst_n || reinit) begin
      prog_n = 0; prog_len = 0; prog_err = 0; ers_len = 0; ers_err = 0;
      gap = 0; rec_err = 0; reads = 0; rd_err = 0; after_ers = 0;
    end else begin
      if (vpp_hv && !a9_hv && !ce_n) begin
        if (p_ce_n) begin
          if (mem_addr != AW'(prog_n) || p_addr != mem_addr || !p_vpp) prog_err++;
          prog_n++;
        end
        prog_len++;
      end else if (prog_len != 0) begin
        if (prog_len != PC) prog_err++;
        prog_len = 0;
      end
      if (a9_hv && vpp_hv && !ce_n) begin
        if (p_ce_n && !(p_a9 && p_vpp)) ers_err++;
        ers_len++;
      end else if (ers_len != 0) begin
        if (ers_len != EC) ers_err++;
        ers_len = 0;
        after_ers = 1;
        gap = 0;
      end
      if (after_ers) begin
        if (!oe_n) begin
          if (gap < RC) rec_err++;
          after_ers = 0;
        end else if (ce_n && !a9_hv && !vpp_hv) gap++;
      end
      if (!oe_n) begin
        reads++;
        if (vpp_hv || a9_hv || ce_n) rd_err++;
      end
      if (done) begin
        exp_t e;
        if (q.size() == 0) chk(0, "R8 unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          chk(pass == e.ok, "R7 pass flag", int'(pass), int'(e.ok));
          chk(int'(attempts) == e.att, "R7 attempt count", int'(attempts), e.att);
          chk(reads == e.reads, "R6 verify read cycles", reads, e.reads);
          chk(!busy, "R8 busy low with done", int'(busy), 0);
          chk(prog_n == NLOC && prog_err == 0, "R2 program sweep", prog_n, NLOC);
          chk(!pre_bad, "R2 array zero before erase", int'(pre_bad), 0);
          chk(ers_err == 0, "R3 erase pulse shape", ers_err, 0);
          chk(rec_err == 0, "R4 recovery gap", rec_err, 0);
          chk(rd_err == 0, "R5 read strobes", rd_err, 0);
        end
      end
      p_ce_n = ce_n; p_vpp = vpp_hv; p_a9 = a9_hv; p_addr = mem_addr;
    end
  end

  task automatic run(input int k, input int stk, input bit ok, input int att,
                     input int rd, input int poke);
    exp_t e;
    @(negedge clk);
    need = k; stuck = stk; reinit = 1'b1;
    @(negedge clk);
    reinit = 1'b0;
    e.ok = ok; e.att = att; e.reads = rd;
    q.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    chk(attempts == '0, "R8 start clears count", int'(attempts), 0);
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      start = 1'b1;            // R9: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    do @(negedge clk); while (!done);
    repeat (6) @(negedge clk);
    chk(int'(attempts) == att, "R8 count held", int'(attempts), att);
    chk(pass == ok, "R8 pass held", int'(pass), int'(ok));
    chk(!done && !busy, "R8 idle after done", int'(done | busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && attempts == '0, "R1 reset status", int'(busy | done), 0);
    chk(ce_n && oe_n && !a9_hv && !vpp_hv, "R1 reset strobes", int'(a9_hv | vpp_hv), 0);
    run(1, -1, 1'b1, 1, 2 * NLOC, 0);            // R3 single pulse pass
    run(3, -1, 1'b1, 3, 4 + 2 * NLOC, 100);      // R6 abort at addr 0, R9 poke
    run(MT, -1, 1'b1, MT, 8 + 2 * NLOC, 0);      // R7 pass on last permitted pulse
    run(1, NLOC - 1, 1'b0, MT, MT * 2 * NLOC, 0);// R7 last-address miss at limit
    run(99, -1, 1'b0, MT, 2 * MT, 0);            // R7 never erases
    run(2, 7, 1'b0, MT, 2 + (MT - 1) * 16, 0);   // R6 stop at stuck addr 7
    chk(q.size() == 0, "R8 all runs completed", q.size(), 0);
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule